// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer/Counter

This peripheral is an 8-bit up-counter with a small register port. A single control register picks one of four behaviours and one of eight count sources. In interval mode the counter restarts after reaching a compare value and toggles an output pin. In either capture mode an edge on a capture pin copies the running count into a latch. In PWM mode the count runs freely and a compare value sets the duty of the output.

The count advances on single-cycle enables in the system clock domain. An enable can come from one of five taps of a free-running prescaler, from either edge of an external count pin after synchronisation, or it can be held off. Two interrupt requests leave the block. The overflow request is set when the count wraps and is cleared by a hardware acknowledge. The match/capture request is set on a compare match or a capture, and only a software write clears it. Each request has its own enable bit.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the control register reads 00h, the count reads 00h, the compare register reads FFh, the capture latch reads 00h, the status register reads 00h, and `timerOut`, `ovfIrq` and `matchIrq` are low.
- R2: Control bits 5:3 select the count source. 000 advances once every 1024 clocks, 001 every 256, 010 every 64, 011 every 8, and 100 every clock, all from a prescaler that counts from reset. 111 holds the count.
- R3: Source 101 counts falling edges of `extClkPin` and 110 counts rising edges. Each edge passes a two-flop synchroniser and moves the count on the second rising clock edge after the pin is sampled.
- R4: Mode 00 (control bits 7:6) is interval mode. On a count enable with the count equal to the compare register, the count goes to 00h, `timerOut` toggles and the match/capture pending flag is set.
- R5: Modes 01 and 10 capture on the rising and falling edge of the synchronised `capPin` respectively. The capture copies the count into the capture latch (address 3) and sets the match/capture pending flag, and the counter keeps running.
- R6: Mode 11 is PWM. The count runs 00h to FFh, and `timerOut` is high exactly while the count is below the compare register.
- R7: A count enable at FFh that is not an interval match wraps the count to 00h and sets the overflow pending flag (status bit 0). `ovfAck` clears the flag, and a new overflow in the same cycle wins.
- R8: Writing control bit 2 as 1 clears the count in that cycle and takes priority over counting. Writing it as 0 does nothing, and it always reads back 0.
- R9: The match/capture pending flag (status bit 1) is cleared only by a status write with bit 1 at 0. Writing 1 has no effect, and a new event in the same cycle wins. Status bit 0 ignores writes.
- R10: `matchIrq` equals the match/capture pending flag ANDed with control bit 1, and `ovfIrq` equals the overflow pending flag ANDed with control bit 0.
- R11: The register port decodes address 0 as control, 1 as count (read-only), 2 as compare (read/write), 3 as capture (read-only) and 4 as status. Writes take effect at the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| extClkPin | input | 1 | External count pin, asynchronous |
| capPin | input | 1 | Capture trigger pin, asynchronous |
| ovfAck | input | 1 | Hardware acknowledge that clears the overflow pending flag |
| timerOut | output | 1 | Interval toggle or PWM output |
| ovfIrq | output | 1 | Overflow interrupt request |
| matchIrq | output | 1 | Match/capture interrupt request |

## Verification
Two pairs of events can fall in the same cycle: a pending flag being set and the same flag being cleared. In one case a capture edge coincides with a software write that clears the match/capture flag. In the other an FFh-to-00h wrap coincides with a held `ovfAck`. The bench provokes the first by rewriting the status register every cycle while `capPin` toggles. It provokes the second by holding `ovfAck` high across several wraps in PWM mode at full speed. A reference model in which setting takes precedence judges the flags and request outputs on every clock. A counter-clear write that coincides with an interval match is also covered: the clear must win, with no toggle and no event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAP  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_CAP_RISE = 2'b01,
    MODE_CAP_FALL = 2'b10,
    MODE_PWM      = 2'b11
  } tmr_mode_e;

  typedef enum logic [2:0] {
    SRC_DIV1024 = 3'b000,
    SRC_DIV256  = 3'b001,
    SRC_DIV64   = 3'b010,
    SRC_DIV8    = 3'b011,
    SRC_DIV1    = 3'b100,
    SRC_EXT_FALL = 3'b101,
    SRC_EXT_RISE = 3'b110,
    SRC_HALT    = 3'b111
  } tmr_src_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic             cntTick;
    logic             capEvt;
    logic             cntClr;
    logic             matchPendClr;
    logic             cmpWr;
    logic [TMR_W-1:0] cmpVal;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseEvt,
  output logic fallEvt
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[SH_W-2:0], pinIn};
  end

  assign riseEvt = shiftQ[STAGES-1] & ~shiftQ[STAGES];
  assign fallEvt = ~shiftQ[STAGES-1] & shiftQ[STAGES];

  assert_edge_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEvt && fallEvt));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 10,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [TMR_W-1:0]  busWdata,
  input  logic              extClkPin,
  input  logic              capPin,
  output logic [TMR_W-1:0]  ctrlReg,
  output tmr_strobe_t       strobe
);
  localparam int SH_A = PRE_W;
  localparam int SH_B = PRE_W - 2;
  localparam int SH_C = PRE_W - 4;
  localparam int SH_D = 3;
  localparam logic [PRE_W-1:0] MASK_A = PRE_W'((1 << SH_A) - 1);
  localparam logic [PRE_W-1:0] MASK_B = PRE_W'((1 << SH_B) - 1);
  localparam logic [PRE_W-1:0] MASK_C = PRE_W'((1 << SH_C) - 1);
  localparam logic [PRE_W-1:0] MASK_D = PRE_W'((1 << SH_D) - 1);
  localparam logic [TMR_W-1:0] WR_MASK = 8'hFB;
  localparam int NPINS = 2;

  logic [PRE_W-1:0] preCnt;
  logic [NPINS-1:0] pinVec, pinRise, pinFall;
  tmr_mode_e        modeSel;
  tmr_src_e         srcSel;
  logic             ctrlWr, statWr;
  logic             tickNow;

  assign pinVec  = {capPin, extClkPin};
  assign modeSel = tmr_mode_e'(ctrlReg[7:6]);
  assign srcSel  = tmr_src_e'(ctrlReg[5:3]);
  assign ctrlWr  = busWrEn && (busAddr == ADDR_CTRL);
  assign statWr  = busWrEn && (busAddr == ADDR_STAT);

  for (genvar p = 0; p < NPINS; p++) begin : g_sync
    tmr_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rstN(rstN), .pinIn(pinVec[p]),
      .riseEvt(pinRise[p]), .fallEvt(pinFall[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      preCnt  <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (ctrlWr) ctrlReg <= busWdata & WR_MASK;
    end
  end

  always_comb begin
    unique case (srcSel)
      SRC_DIV1024:  tickNow = (preCnt & MASK_A) == MASK_A;
      SRC_DIV256:   tickNow = (preCnt & MASK_B) == MASK_B;
      SRC_DIV64:    tickNow = (preCnt & MASK_C) == MASK_C;
      SRC_DIV8:     tickNow = (preCnt & MASK_D) == MASK_D;
      SRC_DIV1:     tickNow = 1'b1;
      SRC_EXT_FALL: tickNow = pinFall[0];
      SRC_EXT_RISE: tickNow = pinRise[0];
      default:      tickNow = 1'b0;
    endcase
  end

  always_comb begin
    strobe.cntTick      = tickNow;
    strobe.capEvt       = ((modeSel == MODE_CAP_RISE) && pinRise[1]) ||
                          ((modeSel == MODE_CAP_FALL) && pinFall[1]);
    strobe.cntClr       = ctrlWr && busWdata[2];
    strobe.matchPendClr = statWr && !busWdata[1];
    strobe.cmpWr        = busWrEn && (busAddr == ADDR_CMP);
    strobe.cmpVal       = busWdata;
  end

  assert_halt_no_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SRC_HALT) |-> !strobe.cntTick);
  assert_clr_bit_reads0_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (ctrlReg[2] == 1'b0));
  assert_cap_only_in_cap_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEvt |-> (modeSel == MODE_CAP_RISE || modeSel == MODE_CAP_FALL));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmr_mode_e        modeSel,
  input  logic             ovfAck,
  input  tmr_strobe_t      strobe,
  output logic [TMR_W-1:0] cntReg,
  output logic [TMR_W-1:0] cmpReg,
  output logic [TMR_W-1:0] capReg,
  output logic             ovfPend,
  output logic             matchPend,
  output logic             timerOut
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;

  logic toggleQ;
  logic isMatch, matchEvt, ovfEvt;

  assign isMatch  = (modeSel == MODE_INTERVAL) && (cntReg == cmpReg);
  assign matchEvt = strobe.capEvt ||
                    (strobe.cntTick && !strobe.cntClr && isMatch);
  assign ovfEvt   = strobe.cntTick && !strobe.cntClr && !isMatch &&
                    (cntReg == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg    <= '0;
      cmpReg    <= CNT_MAX;
      capReg    <= '0;
      toggleQ   <= 1'b0;
      ovfPend   <= 1'b0;
      matchPend <= 1'b0;
    end else begin
      if (strobe.capEvt) capReg <= cntReg;
      if (strobe.cntClr) cntReg <= '0;
      else if (strobe.cntTick) begin
        if (isMatch) begin
          cntReg  <= '0;
          toggleQ <= ~toggleQ;
        end else begin
          cntReg <= cntReg + 1'b1;
        end
      end
      if (strobe.cmpWr) cmpReg <= strobe.cmpVal;
      if (matchEvt)                 matchPend <= 1'b1;
      else if (strobe.matchPendClr) matchPend <= 1'b0;
      if (ovfEvt)      ovfPend <= 1'b1;
      else if (ovfAck) ovfPend <= 1'b0;
    end
  end

  assign timerOut = (modeSel == MODE_PWM) ? (cntReg < cmpReg) : toggleQ;

  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cntReg == '0));
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntTick && !strobe.cntClr) |=> $stable(cntReg));
  assert_interval_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntTick && !strobe.cntClr && modeSel == MODE_INTERVAL &&
     cntReg == cmpReg) |=> (cntReg == '0 && matchPend && toggleQ != $past(toggleQ)));
  assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntTick && !strobe.cntClr && modeSel != MODE_INTERVAL &&
     cntReg == CNT_MAX) |=> (cntReg == '0 && ovfPend));
  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (matchPend && !strobe.matchPendClr) |=> matchPend);
  assert_capture_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capEvt |=> (capReg == $past(cntReg) && matchPend));
endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 10,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [TMR_W-1:0]  busWdata,
  output logic [TMR_W-1:0]  busRdata,
  input  logic              extClkPin,
  input  logic              capPin,
  input  logic              ovfAck,
  output logic              timerOut,
  output logic              ovfIrq,
  output logic              matchIrq
);
  logic [TMR_W-1:0] ctrlReg, cntReg, cmpReg, capReg;
  logic             ovfPend, matchPend;
  tmr_strobe_t      strobe;

  tmr_ctrl #(.PRE_W(PRE_W), .STAGES(STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .extClkPin(extClkPin), .capPin(capPin),
    .ctrlReg(ctrlReg), .strobe(strobe)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .modeSel(tmr_mode_e'(ctrlReg[7:6])),
    .ovfAck(ovfAck), .strobe(strobe), .cntReg(cntReg), .cmpReg(cmpReg),
    .capReg(capReg), .ovfPend(ovfPend), .matchPend(matchPend),
    .timerOut(timerOut)
  );

  assign matchIrq = matchPend & ctrlReg[1];
  assign ovfIrq   = ovfPend & ctrlReg[0];

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = ctrlReg;
      ADDR_CNT:  busRdata = cntReg;
      ADDR_CMP:  busRdata = cmpReg;
      ADDR_CAP:  busRdata = capReg;
      ADDR_STAT: busRdata = {6'b0, matchPend, ovfPend};
      default:   busRdata = '0;
    endcase
  end

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[1] |-> !matchIrq) and (!ctrlReg[0] |-> !ovfIrq));
endmodule

// File: tb/test_tmr8_multimode.sv
module test_tmr8_multimode;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       extClkPin = 1'b0, capPin = 1'b0, ovfAck = 1'b0;
  logic       timerOut, ovfIrq, matchIrq;

  always #2 clk = ~clk;  // 250 MHz

  tmr8_multimode i_tmr8_multimode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .extClkPin(extClkPin),
    .capPin(capPin), .ovfAck(ovfAck), .timerOut(timerOut),
    .ovfIrq(ovfIrq), .matchIrq(matchIrq)
  );

  int    vectors = 0, miscompares = 0;
  bit    done = 0;
  string phase = "R1";

  // behavioural reference model
  int mCtrl, mCnt, mCmp, mCap, mPre;
  bit mTog, mOvfP, mMatchP;
  bit extQ[$], capQ[$];

  function automatic int divOf(int sel);
    case (sel)
      0: return 1024; 1: return 256; 2: return 64; 3: return 8; 4: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mCnt = 0; mCmp = 255; mCap = 0; mPre = 0;
      mTog = 0; mOvfP = 0; mMatchP = 0;
      extQ = '{0, 0, 0}; capQ = '{0, 0, 0};
    end else begin
      int  mode, sel;
      bit  eRise, eFall, cRise, cFall, tick, clr, capEv, matchEv, ovfEv;
      mode = (mCtrl >> 6) & 3; sel = (mCtrl >> 3) & 7;
      // R3: two sampling stages then edge compare
      eRise = extQ[1] && !extQ[2]; eFall = !extQ[1] && extQ[2];
      cRise = capQ[1] && !capQ[2]; cFall = !capQ[1] && capQ[2];
      extQ.push_front(extClkPin); void'(extQ.pop_back());
      capQ.push_front(capPin);    void'(capQ.pop_back());
      if (sel <= 4) tick = (mPre % divOf(sel)) == divOf(sel) - 1;
      else if (sel == 5) tick = eFall;
      else if (sel == 6) tick = eRise;
      else tick = 0;
      mPre = (mPre + 1) % 1024;
      clr = busWrEn && busAddr == 0 && busWdata[2];
      capEv = (mode == 1 && cRise) || (mode == 2 && cFall);
      matchEv = 0; ovfEv = 0;
      if (capEv) begin mCap = mCnt; matchEv = 1; end
      if (clr) mCnt = 0;
      else if (tick) begin
        if (mode == 0 && mCnt == mCmp) begin mCnt = 0; mTog = !mTog; matchEv = 1; end
        else begin
          if (mCnt == 255) ovfEv = 1;
          mCnt = (mCnt + 1) % 256;
        end
      end
      if (matchEv) mMatchP = 1;
      else if (busWrEn && busAddr == 4 && !busWdata[1]) mMatchP = 0;
      if (ovfEv) mOvfP = 1;
      else if (ovfAck) mOvfP = 0;
      if (busWrEn && busAddr == 0) mCtrl = busWdata & 8'hFB;
      if (busWrEn && busAddr == 2) mCmp = busWdata;
    end
  end

  function automatic int expRead(int a);
    case (a)
      0: return mCtrl; 1: return mCnt; 2: return mCmp; 3: return mCap;
      4: return (int'(mMatchP) << 1) | int'(mOvfP);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  // compare on every falling edge, half a cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int mode;
      mode = (mCtrl >> 6) & 3;
      chk(phase, $sformatf("read addr %0d", busAddr), busRdata, expRead(busAddr));
      chk(mode == 3 ? "R6" : "R4", "timerOut", timerOut,
          mode == 3 ? int'(mCnt < mCmp) : int'(mTog));
      chk("R10", "matchIrq", matchIrq, int'(mMatchP && mCtrl[1]));
      chk("R10", "ovfIrq", ovfIrq, int'(mOvfP && mCtrl[0]));
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    busAddr = 3'(a); busWdata = 8'(d); busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic watch(int a, int n);
    busAddr = 3'(a); step(n);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1; #1;
    // R1: every register after reset, R11 address decode
    phase = "R1";
    for (int a = 0; a < 6; a++) watch(a, 1);
    // R4: interval mode at full speed, compare 5, both enables
    phase = "R4";
    wr(2, 5); wr(0, 8'h23); watch(1, 20); watch(4, 4);
    // R9: writing 1 keeps the flag, writing 0 clears it
    phase = "R9";
    wr(4, 8'h02); watch(4, 1); wr(4, 8'h00); watch(4, 1); wr(4, 8'hFF); watch(1, 10);
    // R8: clear, including a clear that coincides with a match; read back bit 2
    phase = "R8";
    wr(0, 8'h27); watch(0, 2); wr(0, 8'h23); watch(1, 3);
    wr(2, 8'h80); watch(1, 40); wr(2, 8'h2A);
    wait_cnt: for (int i = 0; i < 300 && mCnt != 8'h2A; i++) step();
    wr(0, 8'h27); watch(1, 8);
    // R2: prescaler taps and halt
    phase = "R2";
    wr(2, 3); wr(0, 8'h1B); watch(1, 80);
    wr(0, 8'h13); watch(1, 300);
    wr(0, 8'h0B); watch(1, 600);
    wr(0, 8'h03); watch(1, 2200);
    wr(0, 8'h3B); watch(1, 60);
    // R3: external pin, rising then falling
    phase = "R3";
    wr(0, 8'h33);
    for (int i = 0; i < 24; i++) begin extClkPin = ~extClkPin; watch(1, 2 + i % 3); end
    wr(0, 8'h2B);
    for (int i = 0; i < 24; i++) begin extClkPin = ~extClkPin; watch(1, 1 + i % 4); end
    // R5: capture on rising edge, counter keeps running through overflow
    phase = "R5";
    wr(2, 8'hFF); wr(0, 8'h63);
    for (int i = 0; i < 20; i++) begin capPin = ~capPin; watch(3, 7 + i); end
    // R9: clear write every cycle while captures keep landing
    phase = "R9";
    for (int i = 0; i < 48; i++) begin
      if (i % 4 == 0) capPin = ~capPin;
      wr(4, 8'h00);
    end
    watch(4, 4);
    // R5: falling-edge capture
    phase = "R5";
    wr(0, 8'hA3);
    for (int i = 0; i < 16; i++) begin capPin = ~capPin; watch(3, 5 + 2 * i); end
    // R7: overflow acknowledge, held across wraps in PWM at full speed
    phase = "R7";
    wr(2, 8'h40); wr(0, 8'hE3); watch(4, 300);
    ovfAck = 1'b1; watch(4, 600); ovfAck = 1'b0; watch(4, 300);
    for (int i = 0; i < 8; i++) begin ovfAck = 1'b1; step(); ovfAck = 1'b0; watch(4, 40); end
    // R6: PWM duty extremes
    phase = "R6";
    wr(2, 8'h00); watch(1, 300);
    wr(2, 8'hFF); watch(1, 300);
    wr(2, 8'h81); watch(1, 300);
    // R10: disable enables with pending flags set
    phase = "R10";
    wr(0, 8'hE0); watch(4, 300);
    // R11: compare readback
    phase = "R11";
    wr(2, 8'h5A); watch(2, 2); watch(7, 2);
    done = 1;
    summary();
    $finish;
  end
endmodule